// File: doc/BRIEF.md
# Two-write register bank with operand steering

This block holds the eight 32-bit general registers of a small stack-oriented processor and works out which registers an instruction touches. The instruction class nibble, the two register fields of the instruction and the condition outcome come in. The block then produces four register IDs: two sources, the destination for the ALU result (E port) and the destination for the loaded value (M port). It reads both sources combinationally and commits up to two writes on one rising edge.

Stack instructions (push, pop, call, return) use the stack pointer, ID 4, in place of the instruction's own fields. A pop updates the stack pointer and loads a register in the same cycle. A conditional move whose condition fails writes nothing. ID 0xF stands for "no register". Every ID from 8 up reads as zero and cannot be written.

Top module: `gpr_bank`

## Requirements
- R1: When `rst` is high at a rising edge, all eight registers are set to 0 on that edge.
- R2: A read port whose ID is 0..7 returns the contents that register held before the current edge. A read port whose ID is 8..15 (0xF is "no register") returns 0.
- R3: A write whose destination ID is 8..15 changes no register. A register named by neither destination keeps its value.
- R4: Both write ports commit on the same rising edge. When `dst_e_o` equals `dst_m_o`, the register takes the M-port data.
- R5: The class nibble is decoded as follows: 0 halt, 1 nop, 2 register move / conditional move, 3 immediate move, 4 store, 5 load, 6 arithmetic, 7 jump, 8 call, 9 return, 0xA push, 0xB pop. Source A is rA for classes 2, 4, 6 and 0xA. Source B is rB for classes 4, 5 and 6. Any source not listed in R5 or R6 is 0xF.
- R6: Classes 8, 9, 0xA and 0xB use source B = 4 and write the E port to 4. Classes 9 and 0xB also use source A = 4.
- R7: A pop (0xB) writes the E data to register 4 and the M data to rA on the same edge.
- R8: Classes 3 and 6 write the E data to rB, and so does class 2 when `cond_ok_i` is 1. A load (5) writes the M data to rA. The M destination is rA only for classes 5 and 0xB.
- R9: Class 2 with `cond_ok_i` = 0 sets `dst_e_o` to 0xF, and no register changes.
- R10: Classes 0, 1, 4, 7 and 0xC..0xF set both destinations to 0xF and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op_class_i | input | 4 | Instruction class nibble |
| fld_a_i | input | 4 | rA field of the instruction |
| fld_b_i | input | 4 | rB field of the instruction |
| cond_ok_i | input | 1 | Condition outcome for the conditional move |
| wr_e_data_i | input | 32 | ALU result written through the E port |
| wr_m_data_i | input | 32 | Memory result written through the M port |
| src_a_o | output | 4 | Selected source A ID |
| src_b_o | output | 4 | Selected source B ID |
| dst_e_o | output | 4 | Selected E-port destination ID |
| dst_m_o | output | 4 | Selected M-port destination ID |
| rd_a_data_o | output | 32 | Data read through source A |
| rd_b_data_o | output | 32 | Data read through source B |

## Verification
The bench targets a pop into the stack pointer itself, where both ports hit register 4. A design with the wrong priority would leave the incremented pointer there instead of the loaded word. It runs conditional moves with a failed condition: a design that only masks the ID and not the write, or the reverse, would corrupt rB. It writes to IDs 8..15 and reads them: a design that truncates the ID to three bits would alias them onto registers 0..7 and overwrite those. A long pseudo-random sweep reads registers in the cycle they are written, which exposes a write-through path that returns new data too early.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

  localparam int unsigned ID_W = 4;

  typedef logic [ID_W-1:0] reg_id_t;

  localparam reg_id_t ID_NONE = 4'hF;
  localparam reg_id_t ID_SP   = 4'h4;

  typedef enum logic [3:0] {
    CLS_HALT  = 4'h0,
    CLS_NOP   = 4'h1,
    CLS_MOVE  = 4'h2,
    CLS_IMM   = 4'h3,
    CLS_STORE = 4'h4,
    CLS_LOAD  = 4'h5,
    CLS_ARITH = 4'h6,
    CLS_JUMP  = 4'h7,
    CLS_CALL  = 4'h8,
    CLS_RET   = 4'h9,
    CLS_PUSH  = 4'hA,
    CLS_POP   = 4'hB
  } op_class_e;

  // True when an ID names a physical register of a bank with nregs entries.
  function automatic logic id_is_real(reg_id_t id, int unsigned nregs);
    return int'(id) < int'(nregs);
  endfunction

  // True when the class touches the stack pointer.
  function automatic logic cls_is_stack(logic [3:0] cls);
    return (cls == CLS_CALL) || (cls == CLS_RET) ||
           (cls == CLS_PUSH) || (cls == CLS_POP);
  endfunction

endpackage

// File: rtl/gpr_id_select.sv
module gpr_id_select
  import gpr_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic [3:0] op_class_i,
  input  reg_id_t fld_a_i,
  input  reg_id_t fld_b_i,
  input  logic    cond_ok_i,
  output reg_id_t src_a_o,
  output reg_id_t src_b_o,
  output reg_id_t dst_e_o,
  output reg_id_t dst_m_o
);

  logic stack_op;
  assign stack_op = cls_is_stack(op_class_i);

  always_comb begin
    src_a_o = ID_NONE;
    src_b_o = ID_NONE;
    dst_e_o = ID_NONE;
    dst_m_o = ID_NONE;
    case (op_class_i)
      CLS_MOVE: begin
        src_a_o = fld_a_i;
        dst_e_o = cond_ok_i ? fld_b_i : ID_NONE;
      end
      CLS_IMM: begin
        dst_e_o = fld_b_i;
      end
      CLS_STORE: begin
        src_a_o = fld_a_i;
        src_b_o = fld_b_i;
      end
      CLS_LOAD: begin
        src_b_o = fld_b_i;
        dst_m_o = fld_a_i;
      end
      CLS_ARITH: begin
        src_a_o = fld_a_i;
        src_b_o = fld_b_i;
        dst_e_o = fld_b_i;
      end
      CLS_CALL: begin
        src_b_o = ID_SP;
        dst_e_o = ID_SP;
      end
      CLS_RET: begin
        src_a_o = ID_SP;
        src_b_o = ID_SP;
        dst_e_o = ID_SP;
      end
      CLS_PUSH: begin
        src_a_o = fld_a_i;
        src_b_o = ID_SP;
        dst_e_o = ID_SP;
      end
      CLS_POP: begin
        src_a_o = ID_SP;
        src_b_o = ID_SP;
        dst_e_o = ID_SP;
        dst_m_o = fld_a_i;
      end
      default: begin
      end
    endcase
  end

  // R9: a failed conditional move never names an E destination
  p_cmov_cancel_r9: assert property (@(posedge clk) disable iff (rst)
    (op_class_i == CLS_MOVE && !cond_ok_i) |-> (dst_e_o == ID_NONE));

  // R7: pop names the stack pointer on E and rA on M
  p_pop_pair_r7: assert property (@(posedge clk) disable iff (rst)
    (op_class_i == CLS_POP) |-> (dst_e_o == ID_SP && dst_m_o == fld_a_i));

  // R6: every stack class reads and writes the stack pointer
  p_stack_sp_r6: assert property (@(posedge clk) disable iff (rst)
    stack_op |-> (src_b_o == ID_SP && dst_e_o == ID_SP));

  // R10: the M port is only used by load and pop
  p_m_unused_r10: assert property (@(posedge clk) disable iff (rst)
    (op_class_i != CLS_LOAD && op_class_i != CLS_POP) |-> (dst_m_o == ID_NONE));

endmodule

// File: rtl/gpr_storage.sv
module gpr_storage
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  reg_id_t dst_e_i,
  input  reg_id_t dst_m_i,
  input  logic [DATA_W-1:0] wr_e_data_i,
  input  logic [DATA_W-1:0] wr_m_data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs_o
);

  logic [NUM_REGS-1:0] hit_e;
  logic [NUM_REGS-1:0] hit_m;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    assign hit_e[g] = (dst_e_i == reg_id_t'(g));
    assign hit_m[g] = (dst_m_i == reg_id_t'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[g] <= '0;
      end else if (hit_m[g]) begin
        regs_q[g] <= wr_m_data_i;
      end else if (hit_e[g]) begin
        regs_q[g] <= wr_e_data_i;
      end
    end

    // R3: an untargeted register holds its value
    p_hold_unhit_r3: assert property (@(posedge clk) disable iff (rst)
      (!hit_e[g] && !hit_m[g]) |=> $stable(regs_q[g]));

    // R4: when both ports target the same register, M data lands
    p_m_priority_r4: assert property (@(posedge clk) disable iff (rst)
      (hit_e[g] && hit_m[g]) |=> (regs_q[g] == $past(wr_m_data_i)));

    // R8: an E-only hit stores the E data
    p_e_lands_r8: assert property (@(posedge clk) disable iff (rst)
      (hit_e[g] && !hit_m[g]) |=> (regs_q[g] == $past(wr_e_data_i)));
  end

  assign regs_o = regs_q;

endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  reg_id_t id_i,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
  output logic [DATA_W-1:0] data_o
);

  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  logic real_id;
  assign real_id = id_is_real(id_i, NUM_REGS);

  always_comb begin
    data_o = '0;
    if (real_id) begin
      data_o = regs_i[id_i[IDX_W-1:0]];
    end
  end

  // R2: IDs past the bank read as zero
  p_none_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (int'(id_i) >= int'(NUM_REGS)) |-> (data_o == '0));

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import gpr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_class_i,
  input  logic [3:0]        fld_a_i,
  input  logic [3:0]        fld_b_i,
  input  logic              cond_ok_i,
  input  logic [DATA_W-1:0] wr_e_data_i,
  input  logic [DATA_W-1:0] wr_m_data_i,
  output logic [3:0]        src_a_o,
  output logic [3:0]        src_b_o,
  output logic [3:0]        dst_e_o,
  output logic [3:0]        dst_m_o,
  output logic [DATA_W-1:0] rd_a_data_o,
  output logic [DATA_W-1:0] rd_b_data_o
);

  localparam int unsigned N_RD = 2;

  reg_id_t sel_src_a, sel_src_b, sel_dst_e, sel_dst_m;
  reg_id_t rd_id   [N_RD];
  logic [DATA_W-1:0] rd_data [N_RD];
  logic [NUM_REGS-1:0][DATA_W-1:0] bank;

  gpr_id_select u_sel (
    .clk        (clk),
    .rst        (rst),
    .op_class_i (op_class_i),
    .fld_a_i    (fld_a_i),
    .fld_b_i    (fld_b_i),
    .cond_ok_i  (cond_ok_i),
    .src_a_o    (sel_src_a),
    .src_b_o    (sel_src_b),
    .dst_e_o    (sel_dst_e),
    .dst_m_o    (sel_dst_m)
  );

  gpr_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk         (clk),
    .rst         (rst),
    .dst_e_i     (sel_dst_e),
    .dst_m_i     (sel_dst_m),
    .wr_e_data_i (wr_e_data_i),
    .wr_m_data_i (wr_m_data_i),
    .regs_o      (bank)
  );

  assign rd_id[0] = sel_src_a;
  assign rd_id[1] = sel_src_b;

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    gpr_read_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd (
      .clk    (clk),
      .rst    (rst),
      .id_i   (rd_id[p]),
      .regs_i (bank),
      .data_o (rd_data[p])
    );
  end

  assign src_a_o     = sel_src_a;
  assign src_b_o     = sel_src_b;
  assign dst_e_o     = sel_dst_e;
  assign dst_m_o     = sel_dst_m;
  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

  // R2: reading the register written on the previous edge returns that data
  p_read_after_e_r2: assert property (@(posedge clk) disable iff (rst)
    (int'(sel_dst_e) < int'(NUM_REGS) && sel_dst_m != sel_dst_e) |=>
      ((sel_src_a != $past(sel_dst_e)) || (rd_a_data_o == $past(wr_e_data_i)) ||
       (sel_src_a == $past(sel_dst_m))));

endmodule

// File: tb/gpr_bank_tb_top.sv
`timescale 1ns/1ps
module gpr_bank_tb_top;

  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op = 4'h1, fa = 4'hF, fb = 4'hF;
  logic        cond = 1'b0;
  logic [31:0] we = '0, wm = '0;
  logic [3:0]  sa, sb, de, dm;
  logic [31:0] ra, rb;

  always #(CLK_NS/2) clk = ~clk;

  gpr_bank dut_i (
    .clk(clk), .rst(rst), .op_class_i(op), .fld_a_i(fa), .fld_b_i(fb),
    .cond_ok_i(cond), .wr_e_data_i(we), .wr_m_data_i(wm),
    .src_a_o(sa), .src_b_o(sb), .dst_e_o(de), .dst_m_o(dm),
    .rd_a_data_o(ra), .rd_b_data_o(rb)
  );

  typedef struct {
    string       tag;
    int          sig;
    logic [31:0] exp;
  } item_t;

  item_t       sb_q[$];
  event        ev_check;
  int          n_total = 0, n_fail = 0;
  bit          finished = 0;
  logic [31:0] model [8];

  function automatic logic [31:0] pick(int s);
    case (s)
      0: return {28'd0, sa};
      1: return {28'd0, sb};
      2: return {28'd0, de};
      3: return {28'd0, dm};
      4: return ra;
      default: return rb;
    endcase
  endfunction

  function automatic string sname(int s);
    case (s)
      0: return "src_a"; 1: return "src_b"; 2: return "dst_e";
      3: return "dst_m"; 4: return "rd_a";  default: return "rd_b";
    endcase
  endfunction

  // monitor: pops expected items and compares them with the ports
  initial begin
    forever begin
      @(ev_check);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        act = pick(it.sig);
        n_total++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s %s actual=%h expected=%h", it.tag, sname(it.sig), act, it.exp);
        end
      end
    end
  end

  function automatic logic [31:0] mread(logic [3:0] id);
    return (id < 4'd8) ? model[id[2:0]] : 32'd0;
  endfunction

  task automatic push_item(string tag, int s, logic [31:0] v);
    item_t it;
    it.tag = tag; it.sig = s; it.exp = v;
    sb_q.push_back(it);
  endtask

  // driver: applies one instruction, queues its expected outputs, then models the edge
  task automatic step(input logic [3:0] o, input logic [3:0] a, input logic [3:0] b,
                      input logic c, input logic [31:0] e, input logic [31:0] m,
                      input string tag);
    logic [3:0] xa, xb, xe, xm;
    @(negedge clk);
    op = o; fa = a; fb = b; cond = c; we = e; wm = m;
    xa = 4'hF; xb = 4'hF; xe = 4'hF; xm = 4'hF;
    if (o == 4'h2 || o == 4'h4 || o == 4'h6 || o == 4'hA) xa = a;
    else if (o == 4'h9 || o == 4'hB) xa = 4'h4;
    if (o == 4'h4 || o == 4'h5 || o == 4'h6) xb = b;
    else if (o >= 4'h8 && o <= 4'hB) xb = 4'h4;
    if (o == 4'h3 || o == 4'h6 || (o == 4'h2 && c)) xe = b;
    else if (o >= 4'h8 && o <= 4'hB) xe = 4'h4;
    if (o == 4'h5 || o == 4'hB) xm = a;
    push_item(tag, 0, {28'd0, xa});
    push_item(tag, 1, {28'd0, xb});
    push_item(tag, 2, {28'd0, xe});
    push_item(tag, 3, {28'd0, xm});
    push_item(tag, 4, mread(xa));
    push_item(tag, 5, mread(xb));
    #2;
    ->ev_check;
    #1;
    if (xe < 4'd8) model[xe[2:0]] = e;
    if (xm < 4'd8) model[xm[2:0]] = m;
  endtask

  task automatic read_pair(logic [3:0] a, logic [3:0] b, string tag);
    step(4'h4, a, b, 1'b0, 32'hDEAD_0000, 32'hBEEF_0000, tag);
  endtask

  task automatic read_all(string tag);
    for (int i = 0; i < 8; i += 2) read_pair(4'(i), 4'(i + 1), tag);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
  endtask

  initial begin
    #(CLK_NS * 60000);
    if (!finished) begin
      n_total++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < 8; i++) model[i] = 32'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    read_all("R1 reset clears");

    for (int i = 0; i < 8; i++)
      step(4'h3, 4'hF, 4'(i), 1'b0, 32'h1000_0000 + 32'(i * 17), 32'h5555_5555, "R8 imm move");
    read_all("R2 read back");
    read_pair(4'hF, 4'h9, "R2 unnamed ids read zero");

    step(4'h3, 4'hF, 4'hF, 1'b0, 32'hAAAA_0001, 32'h0, "R3 write to none");
    step(4'h3, 4'h0, 4'hA, 1'b0, 32'hAAAA_0002, 32'h0, "R3 write to id 10");
    step(4'h5, 4'hC, 4'h1, 1'b0, 32'h0, 32'hAAAA_0003, "R3 load to id 12");
    read_all("R3 bank untouched");

    step(4'h6, 4'h1, 4'h2, 1'b0, 32'h0000_1234, 32'h0, "R5 arith");
    step(4'h6, 4'h2, 4'h2, 1'b0, 32'h0000_5678, 32'h0, "R2 read old during write");
    step(4'h5, 4'h3, 4'h5, 1'b0, 32'h0, 32'hCAFE_0003, "R8 load to rA");
    step(4'h2, 4'h0, 4'h6, 1'b0, 32'hBAD0_0006, 32'h0, "R9 cmov false");
    read_pair(4'h6, 4'h0, "R9 rB unchanged");
    step(4'h2, 4'h0, 4'h6, 1'b1, 32'h600D_0006, 32'h0, "R8 cmov true");
    step(4'hA, 4'h7, 4'h1, 1'b0, 32'h0000_0080, 32'h0, "R6 push");
    step(4'hB, 4'h5, 4'h0, 1'b0, 32'h0000_0084, 32'h5050_0005, "R7 pop dual write");
    read_pair(4'h4, 4'h5, "R7 both landed");
    step(4'hB, 4'h4, 4'h0, 1'b0, 32'h0000_0088, 32'h4444_0004, "R4 pop into sp, M wins");
    read_pair(4'h4, 4'h4, "R4 sp holds M data");
    step(4'h8, 4'h3, 4'h2, 1'b0, 32'h0000_0100, 32'h9999_9999, "R6 call");
    step(4'h9, 4'h3, 4'h2, 1'b0, 32'h0000_0104, 32'h9999_9999, "R6 return");
    for (int o = 0; o < 16; o++)
      if (o == 0 || o == 1 || o == 7 || o >= 12)
        step(4'(o), 4'h1, 4'h2, 1'b1, 32'hEEEE_EEEE, 32'hDDDD_DDDD, "R10 no write class");
    read_all("R10 bank untouched");

    lfsr = 32'h1ACE_B00C;
    for (int k = 0; k < 400; k++) begin
      logic [31:0] d1, d2;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      d1 = lfsr * 32'd2654435761;
      d2 = ~lfsr + 32'd7;
      step(lfsr[3:0], lfsr[7:4], lfsr[11:8], lfsr[12], d1, d2, "R5 sweep");
    end
    read_all("R4 sweep final");

    finished = 1;
    report();
    $finish;
  end

endmodule